// File: doc/BRIEF.md
# Protecting-Distance Set Replacement Controller

This block keeps the replacement state of a single set in a set-associative cache. Every way carries a short countdown, its remaining protection, and a flag that records whether the line has been hit since it was filled. Each access to the set reloads the countdown of the way it touches with the current protecting distance, and counts down every other way, stopping at zero. A way whose countdown has reached zero is no longer protected and may be replaced.

On a miss the block names a victim way in the same cycle, using only combinational logic over the stored state. If no way is unprotected, the mode input decides what happens. In non-inclusive operation the incoming line is not allocated at all, and the block raises a bypass flag. In inclusive operation it evicts the most protected line that has never been hit, or the most protected line overall when every line has been hit. The protecting distance comes in as an 8-bit value below 256. Its upper bits are kept to fit the narrow per-way field. Tags, data and the calculation of the distance are handled elsewhere.

Top module: `prot_dist_repl`

## Requirements
- R1: After reset every way has a countdown of zero and a cleared reused flag, so the first miss selects way 0 with no bypass, and the valid strobe stays low while no access is presented.
- R2: `victimValid` is high in exactly those cycles where `accValid` is high and `accHit` is low. `bypass` is never high without `victimValid`.
- R3: On a miss where at least one countdown is zero, the victim is the lowest-numbered way whose countdown is zero, and `bypass` is low.
- R4: The way that is filled on a miss, or hit, is loaded with `protDist >> (PD_W - RPD_W)`. With the defaults this is `protDist[7:5]`.
- R5: On every access, each way that is not loaded has its countdown reduced by one, saturating at zero. On a bypass this applies to all ways.
- R6: With `inclMode` = 0 (non-inclusive), a miss that finds every countdown nonzero raises `bypass`, and no way is loaded.
- R7: With `inclMode` = 1 (inclusive), a miss that finds every countdown nonzero evicts the never-reused way with the highest countdown. When several such ways share the highest countdown, the lowest-numbered one wins.
- R8: In the R7 case, if every way has been reused, the victim is the way with the highest countdown overall. When several ways share the highest countdown, the lowest-numbered one wins.
- R9: A filled way has its reused flag cleared, and a hit way has its reused flag set.
- R10: On a hit access, `victimValid` and `bypass` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access to this set is presented this cycle |
| accHit | input | 1 | 1 = the access hit, 0 = it missed |
| hitWay | input | $clog2(WAYS) | Way that hit, used when `accHit` is 1 |
| protDist | input | PD_W | Current protecting distance, full precision |
| inclMode | input | 1 | 1 = inclusive (always replace), 0 = non-inclusive (may bypass) |
| victimWay | output | $clog2(WAYS) | Way to replace, meaningful when `victimValid` is 1 and `bypass` is 0 |
| bypass | output | 1 | Miss must not allocate a line |
| victimValid | output | 1 | Victim decision valid (miss access) |

## Verification
A countdown that is wrong, or a reused flag that is wrong, stays invisible until a later miss has to choose between ways. It then shows up as the wrong victim index, or as a bypass that should not have happened, or the reverse. This usually happens within the next few accesses, because every access moves all of the counters. The bench keeps its own per-way countdowns and flags and predicts the decision of every miss. It uses a small set, so that fully protected sets occur often, and it uses a mix of distances that includes values which scale down to zero.

// File: rtl/prot_dist_pkg.sv
package prot_dist_pkg;
  // Strobes sent from the control to the state datapath.
  typedef struct packed {
    logic stepEn;      // an access happens: count down the untouched ways
    logic loadEn;      // one way is reloaded this access
    logic markReused;  // reloaded way came from a hit
  } replStrb_t;
endpackage

// File: rtl/prot_dist_ctrl.sv
module prot_dist_ctrl
  import prot_dist_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int RPD_W = 3,
  parameter int PD_W  = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SHIFT = PD_W - RPD_W
) (
  input  logic                        accValid,
  input  logic                        accHit,
  input  logic [WAY_W-1:0]            hitWay,
  input  logic [PD_W-1:0]             protDist,
  input  logic                        inclMode,
  input  logic [WAYS-1:0][RPD_W-1:0]  rpdVec,
  input  logic [WAYS-1:0]             reusedVec,
  output logic [WAY_W-1:0]            victimWay,
  output logic                        bypass,
  output logic                        victimValid,
  output replStrb_t                   strb,
  output logic [WAY_W-1:0]            loadWay,
  output logic [RPD_W-1:0]            loadVal
);

  logic              anyZero;
  logic [WAY_W-1:0]  zeroIdx;
  logic              anyFresh;
  logic [WAY_W-1:0]  freshIdx;
  logic [RPD_W-1:0]  freshMax;
  logic [WAY_W-1:0]  allIdx;
  logic [RPD_W-1:0]  allMax;
  logic              isMiss;

  // Lowest-numbered unprotected way: scan downward so the lowest index stays.
  always_comb begin
    anyZero = 1'b0;
    zeroIdx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (rpdVec[i] == '0) begin
        anyZero = 1'b1;
        zeroIdx = WAY_W'(i);
      end
    end
  end

  // Highest countdown among never-reused ways and among all ways.
  // The comparison is strict, so on a tie the lowest index is kept.
  always_comb begin
    anyFresh = 1'b0;
    freshIdx = '0;
    freshMax = '0;
    allIdx   = '0;
    allMax   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!reusedVec[i] && (!anyFresh || rpdVec[i] > freshMax)) begin
        anyFresh = 1'b1;
        freshMax = rpdVec[i];
        freshIdx = WAY_W'(i);
      end
      if (rpdVec[i] > allMax) begin
        allMax = rpdVec[i];
        allIdx = WAY_W'(i);
      end
    end
  end

  assign isMiss      = accValid && !accHit;
  assign victimValid = isMiss;

  always_comb begin
    bypass    = 1'b0;
    victimWay = '0;
    if (isMiss) begin
      if (anyZero) begin
        victimWay = zeroIdx;
      end else if (!inclMode) begin
        bypass = 1'b1;
      end else if (anyFresh) begin
        victimWay = freshIdx;
      end else begin
        victimWay = allIdx;
      end
    end
  end

  assign loadVal         = protDist[PD_W-1:SHIFT];
  assign loadWay         = accHit ? hitWay : victimWay;
  assign strb.stepEn     = accValid;
  assign strb.loadEn     = accValid && (accHit || !bypass);
  assign strb.markReused = accHit;

endmodule

// File: rtl/prot_dist_dp.sv
module prot_dist_dp
  import prot_dist_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int RPD_W = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  replStrb_t                   strb,
  input  logic [WAY_W-1:0]            loadWay,
  input  logic [RPD_W-1:0]            loadVal,
  output logic [WAYS-1:0][RPD_W-1:0]  rpdVec,
  output logic [WAYS-1:0]             reusedVec
);

  for (genvar g = 0; g < WAYS; g++) begin : gWay
    logic hitMe;
    assign hitMe = strb.loadEn && (loadWay == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rpdVec[g]    <= '0;
        reusedVec[g] <= 1'b0;
      end else if (strb.stepEn) begin
        if (hitMe) begin
          rpdVec[g]    <= loadVal;
          reusedVec[g] <= strb.markReused;
        end else if (rpdVec[g] != '0) begin
          rpdVec[g] <= rpdVec[g] - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/prot_dist_repl.sv
module prot_dist_repl
  import prot_dist_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int RPD_W = 3,
  parameter int PD_W  = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accHit,
  input  logic [WAY_W-1:0] hitWay,
  input  logic [PD_W-1:0]  protDist,
  input  logic             inclMode,
  output logic [WAY_W-1:0] victimWay,
  output logic             bypass,
  output logic             victimValid
);

  replStrb_t                  strb;
  logic [WAY_W-1:0]           loadWay;
  logic [RPD_W-1:0]           loadVal;
  logic [WAYS-1:0][RPD_W-1:0] rpdVec;
  logic [WAYS-1:0]            reusedVec;

  prot_dist_ctrl #(.WAYS(WAYS), .RPD_W(RPD_W), .PD_W(PD_W)) ctrl_i (
    .accValid   (accValid),
    .accHit     (accHit),
    .hitWay     (hitWay),
    .protDist   (protDist),
    .inclMode   (inclMode),
    .rpdVec     (rpdVec),
    .reusedVec  (reusedVec),
    .victimWay  (victimWay),
    .bypass     (bypass),
    .victimValid(victimValid),
    .strb       (strb),
    .loadWay    (loadWay),
    .loadVal    (loadVal)
  );

  prot_dist_dp #(.WAYS(WAYS), .RPD_W(RPD_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadWay  (loadWay),
    .loadVal  (loadVal),
    .rpdVec   (rpdVec),
    .reusedVec(reusedVec)
  );

endmodule

// File: rtl/prot_dist_repl_chk.sv
module prot_dist_repl_chk #(
  parameter int WAYS  = 16,
  parameter int RPD_W = 3,
  parameter int PD_W  = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SHIFT = PD_W - RPD_W
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        accValid,
  input logic                        accHit,
  input logic [WAY_W-1:0]            hitWay,
  input logic [PD_W-1:0]             protDist,
  input logic                        inclMode,
  input logic [WAY_W-1:0]            victimWay,
  input logic                        bypass,
  input logic                        victimValid,
  input logic [WAYS-1:0][RPD_W-1:0]  rpdVec,
  input logic [WAYS-1:0]             reusedVec
);

  logic             someZero;
  logic             allReused;
  logic             victimIsTop;
  logic             willLoad;
  logic [WAY_W-1:0] touchedWay;
  logic [RPD_W-1:0] scaledPd;

  always_comb begin
    someZero    = 1'b0;
    victimIsTop = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      if (rpdVec[i] == '0) someZero = 1'b1;
      if (rpdVec[i] > rpdVec[victimWay]) victimIsTop = 1'b0;
    end
  end

  assign allReused  = &reusedVec;
  assign willLoad   = accValid && (accHit || !bypass);
  assign touchedWay = accHit ? hitWay : victimWay;
  assign scaledPd   = RPD_W'(protDist >> SHIFT);

  assert_valid_on_miss_R2: assert property (@(posedge clk) disable iff (!rstN)
    victimValid == (accValid && !accHit));

  assert_bypass_needs_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> victimValid);

  assert_zero_way_taken_R3: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && someZero) |-> (!bypass && rpdVec[victimWay] == '0));

  assert_load_distance_R4: assert property (@(posedge clk) disable iff (!rstN)
    willLoad |=> rpdVec[$past(touchedWay)] == $past(scaledPd));

  assert_bypass_conditions_R6: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> (!inclMode && !someZero));

  assert_full_set_replaced_R7: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && inclMode && !someZero) |-> (!bypass && (allReused || !reusedVec[victimWay])));

  assert_top_countdown_R8: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && inclMode && !someZero && allReused) |-> victimIsTop);

  assert_hit_marks_reused_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accHit) |=> reusedVec[$past(hitWay)]);

  assert_hit_no_victim_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accHit) |-> (!victimValid && !bypass));

  for (genvar g = 0; g < WAYS; g++) begin : gStep
    assert_countdown_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      (accValid && !(willLoad && touchedWay == WAY_W'(g))) |=>
        rpdVec[g] == (($past(rpdVec[g]) == '0) ? '0 : $past(rpdVec[g]) - 1'b1));
  end

endmodule

bind prot_dist_repl prot_dist_repl_chk #(.WAYS(WAYS), .RPD_W(RPD_W), .PD_W(PD_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .accValid   (accValid),
  .accHit     (accHit),
  .hitWay     (hitWay),
  .protDist   (protDist),
  .inclMode   (inclMode),
  .victimWay  (victimWay),
  .bypass     (bypass),
  .victimValid(victimValid),
  .rpdVec     (rpdVec),
  .reusedVec  (reusedVec)
);

// File: tb/prot_dist_repl_tb_top.sv
module prot_dist_repl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW    = 4;
  localparam int RW    = 3;
  localparam int PW    = 8;
  localparam int WW    = $clog2(NW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accValid = 1'b0;
  logic          accHit = 1'b0;
  logic [WW-1:0] hitWay = '0;
  logic [PW-1:0] protDist = '0;
  logic          inclMode = 1'b0;
  logic [WW-1:0] victimWay;
  logic          bypass;
  logic          victimValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state of the set.
  int mRpd[NW];
  bit mReused[NW];

  always #(CLK_PERIOD / 2) clk = ~clk;

  prot_dist_repl #(.WAYS(NW), .RPD_W(RW), .PD_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit), .hitWay(hitWay),
    .protDist(protDist), .inclMode(inclMode), .victimWay(victimWay),
    .bypass(bypass), .victimValid(victimValid)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    accValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    foreach (mRpd[i]) begin
      mRpd[i] = 0;
      mReused[i] = 0;
    end
  endtask

  // One access: drive, predict, compare, then advance the model past the edge.
  task automatic access(bit hit, int way, int pd, bit incl, string tagIn);
    int zeroIdx, freshIdx, freshMax, allIdx, allMax, expWay, loadIdx;
    bit expByp;
    string tag;
    @(negedge clk);
    accValid = 1'b1;
    accHit   = hit;
    hitWay   = WW'(way);
    protDist = PW'(pd);
    inclMode = incl;
    #1;
    zeroIdx = -1; freshIdx = -1; freshMax = -1; allIdx = 0; allMax = -1;
    for (int i = 0; i < NW; i++) begin
      if (mRpd[i] == 0 && zeroIdx < 0) zeroIdx = i;
      if (!mReused[i] && mRpd[i] > freshMax) begin freshMax = mRpd[i]; freshIdx = i; end
      if (mRpd[i] > allMax) begin allMax = mRpd[i]; allIdx = i; end
    end
    expByp = 0; expWay = 0;
    if (hit)                 tag = "R10";
    else if (zeroIdx >= 0)   begin tag = "R3"; expWay = zeroIdx; end
    else if (!incl)          begin tag = "R6"; expByp = 1; end
    else if (freshIdx >= 0)  begin tag = "R7"; expWay = freshIdx; end
    else                     begin tag = "R8"; expWay = allIdx; end
    if (tagIn != "") tag = tagIn;
    check(tag, int'(victimValid), int'(!hit), "victimValid");
    check(tag, int'(bypass), int'(expByp), "bypass");
    if (!hit && !expByp) check(tag, int'(victimWay), expWay, "victimWay");
    loadIdx = hit ? way : (expByp ? -1 : expWay);
    @(posedge clk);
    for (int i = 0; i < NW; i++) begin
      if (i == loadIdx) begin
        mRpd[i] = pd >> (PW - RW);   // R4
        mReused[i] = hit;            // R9
      end else if (mRpd[i] > 0) begin
        mRpd[i] = mRpd[i] - 1;       // R5
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R1", int'(victimValid), 0, "victimValid idle");
    check("R1", int'(bypass), 0, "bypass idle");
    // Fill from reset: lowest zero way each time.
    access(0, 0, 255, 0, "R1");
    access(0, 0, 255, 0, "R3");
    access(0, 0, 255, 0, "R3");
    access(0, 0, 255, 0, "R3");
    // All protected, non-inclusive: bypass twice, everything counts down.
    access(0, 0, 255, 0, "R6");
    access(0, 0, 255, 0, "R6");
    // Hit way 1 marks it reused; inclusive miss then picks the highest fresh way (3).
    access(1, 1, 255, 1, "R9");
    access(0, 0, 255, 1, "R7");
    access(0, 0, 255, 1, "R3");
    // Every way reused: inclusive miss takes the highest countdown (way 3).
    doReset();
    for (int w = 0; w < NW; w++) access(1, w, 255, 1, "R10");
    access(0, 0, 255, 1, "R8");
    // Scaled distance 64 -> 2: way 0 reaches zero after two further accesses.
    doReset();
    access(0, 0, 64, 1, "R4");
    access(0, 0, 64, 1, "R4");
    access(0, 0, 64, 1, "R5");
    // Distance that scales to zero leaves the way unprotected at once.
    access(0, 0, 20, 0, "R4");
    // Mixed traffic against the model.
    doReset();
    for (int n = 0; n < 3000; n++) begin
      int pdSel;
      pdSel = $urandom_range(0, 3);
      access(bit'($urandom_range(0, 2) == 0), $urandom_range(0, NW - 1),
             (pdSel == 0) ? $urandom_range(0, 31) : $urandom_range(128, 255),
             bit'($urandom_range(0, 1)), "");
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        accValid = 1'b0;
        #1;
        check("R2", int'(victimValid), 0, "victimValid idle");
      end
    end
    @(negedge clk);
    accValid = 1'b0;
    report();
  end

endmodule